// File: doc/BRIEF.md
# Accumulator ALU with Carry/Borrow Flag

This unit keeps an accumulator byte and a one-bit carry/borrow flag in registers. On each cycle where the write strobe is high, it combines the accumulator with an operand byte under a four-bit operation code. It writes the result back to the accumulator and, for the operations that affect it, updates the flag. The operations cover bitwise logic, addition with and without carry-in, subtraction in both operand orders with and without borrow-in, plain shifts, and rotates that pass through the flag.

For subtraction the flag means "no borrow": it is 1 when the result did not go below zero, and 0 when it did, in which case the accumulator holds the two's-complement difference. The borrow-in of the borrow forms is the inverse of the flag. Because of this, a chain of byte-wide adds or subtracts builds a wider arithmetic result across several strobes. The logic operations never touch the flag, so an operand can be moved into the accumulator between chained steps without losing the carry.

Fetching the operand and choosing addresses belong to the surrounding datapath. This unit only sees the byte that arrives on its operand input.

Top module: `dacc_alu`

## Requirements
- R1: A synchronous high reset clears the accumulator to 0 and leaves the flag at the value it held before the reset, even when the write strobe is high in the same cycle.
- R2: While the write strobe is low, neither the accumulator nor the flag changes, whatever the operation code and operand.
- R3: Codes 0, 1 and 2 load the accumulator with the bitwise AND, OR and XOR of accumulator and operand, and leave the flag unchanged.
- R4: Code 3 adds operand and accumulator without carry-in; the accumulator takes the low byte and the flag takes the carry out of bit 7, whatever the flag held before.
- R5: Code 4 adds operand, accumulator and the flag; the accumulator takes the low byte and the flag takes the carry out, so that chained byte adds form a wider sum.
- R6: Code 5 computes operand minus accumulator and code 6 computes accumulator minus operand, both as if the flag were 1 on entry; the flag becomes 1 when no borrow occurs (minuend not below subtrahend) and 0 otherwise, with the accumulator holding the two's-complement difference.
- R7: Code 7 computes operand minus accumulator minus (NOT flag) and code 8 computes accumulator minus operand minus (NOT flag), with the same meaning of the flag afterwards as in R6.
- R8: Code 9 shifts the accumulator right by one; bit 0 goes to the flag and bit 7 becomes 0.
- R9: Code 10 rotates right through the flag; bit 0 goes to the flag and the old flag goes to bit 7.
- R10: Code 11 shifts the accumulator left by one, with bit 7 going to the flag and 0 into bit 0. Code 12 does the same but puts the old flag into bit 0.
- R11: Codes 13 to 15 are reserved. A strobe with one of them leaves both the accumulator and the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the accumulator |
| we | input | 1 | Write strobe; applies the selected operation this cycle |
| op_sel | input | 4 | Operation code, values as listed in the requirements |
| operand | input | WIDTH | Operand byte |
| d_out | output | WIDTH | Accumulator contents |
| df_out | output | 1 | Carry/borrow flag |

## Verification
The bench builds the unit at its default width of eight bits. At that width, hand-worked vectors can reach the carry out of bit 7, the equal-operand subtract that sits exactly on the borrow boundary, and the all-ones result of a borrow-in that wraps through zero. A two-byte chained add shows the flag carrying between strobes while a logic operation in between leaves it untouched. Directed sequences then hold the strobe low and assert reset with the strobe high, checking that the flag survives both.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND  = 4'd0,
        OP_OR   = 4'd1,
        OP_XOR  = 4'd2,
        OP_ADD  = 4'd3,
        OP_ADC  = 4'd4,
        OP_SUBM = 4'd5,
        OP_SUBD = 4'd6,
        OP_SBBM = 4'd7,
        OP_SBBD = 4'd8,
        OP_SHR  = 4'd9,
        OP_RORC = 4'd10,
        OP_SHL  = 4'd11,
        OP_ROLC = 4'd12
    } alu_op_e;

    // Control word for the shared adder: which input is the minuend,
    // whether the second input is inverted, and where the carry-in comes from.
    typedef struct packed {
        logic swap;       // first adder input is the accumulator
        logic invert;     // subtract: add the one's complement
        logic use_flag;   // carry-in taken from the flag
        logic fixed_cin;  // carry-in value when the flag is not used
    } arith_ctl_t;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_LOGIC = 2'd1,
        CLS_ARITH = 2'd2,
        CLS_SHIFT = 2'd3
    } op_class_e;

    function automatic op_class_e classify(input logic [3:0] code);
        case (code)
            OP_AND, OP_OR, OP_XOR:                         classify = CLS_LOGIC;
            OP_ADD, OP_ADC, OP_SUBM, OP_SUBD,
            OP_SBBM, OP_SBBD:                              classify = CLS_ARITH;
            OP_SHR, OP_RORC, OP_SHL, OP_ROLC:              classify = CLS_SHIFT;
            default:                                       classify = CLS_NONE;
        endcase
    endfunction

    function automatic arith_ctl_t arith_decode(input logic [3:0] code);
        arith_ctl_t c;
        c = '0;
        case (code)
            OP_ADD:  c = '{swap: 1'b0, invert: 1'b0, use_flag: 1'b0, fixed_cin: 1'b0};
            OP_ADC:  c = '{swap: 1'b0, invert: 1'b0, use_flag: 1'b1, fixed_cin: 1'b0};
            OP_SUBM: c = '{swap: 1'b0, invert: 1'b1, use_flag: 1'b0, fixed_cin: 1'b1};
            OP_SUBD: c = '{swap: 1'b1, invert: 1'b1, use_flag: 1'b0, fixed_cin: 1'b1};
            OP_SBBM: c = '{swap: 1'b0, invert: 1'b1, use_flag: 1'b1, fixed_cin: 1'b0};
            OP_SBBD: c = '{swap: 1'b1, invert: 1'b1, use_flag: 1'b1, fixed_cin: 1'b0};
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [3:0]       code,
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] opnd,
    output logic [WIDTH-1:0] result
);
    always_comb begin
        case (code)
            OP_AND:  result = acc & opnd;
            OP_OR:   result = acc | opnd;
            OP_XOR:  result = acc ^ opnd;
            default: result = acc;
        endcase
    end
endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  arith_ctl_t       ctl,
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] opnd,
    input  logic             flag,
    output logic [WIDTH-1:0] result,
    output logic             carry
);
    localparam int SUM_W = WIDTH + 1;

    logic [WIDTH-1:0] in_a;
    logic [WIDTH-1:0] in_b;
    logic [WIDTH-1:0] in_b_eff;
    logic             cin;
    logic [SUM_W-1:0] total;

    always_comb begin
        in_a     = ctl.swap ? acc  : opnd;
        in_b     = ctl.swap ? opnd : acc;
        in_b_eff = ctl.invert ? ~in_b : in_b;
        cin      = ctl.use_flag ? flag : ctl.fixed_cin;
        // For subtraction the carry out of a + ~b + cin is the no-borrow bit.
        total    = {1'b0, in_a} + {1'b0, in_b_eff} + {{WIDTH{1'b0}}, cin};
        result   = total[WIDTH-1:0];
        carry    = total[WIDTH];
    end
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [3:0]       code,
    input  logic [WIDTH-1:0] acc,
    input  logic             flag,
    output logic [WIDTH-1:0] result,
    output logic             flag_out
);
    logic fill;
    logic go_left;

    always_comb begin
        go_left = (code == OP_SHL) || (code == OP_ROLC);
        fill    = ((code == OP_RORC) || (code == OP_ROLC)) ? flag : 1'b0;
    end

    logic [WIDTH-1:0] right_v;
    logic [WIDTH-1:0] left_v;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bits
        if (i == WIDTH - 1) begin : g_top
            assign right_v[i] = fill;
        end else begin : g_mid_r
            assign right_v[i] = acc[i+1];
        end
        if (i == 0) begin : g_bot
            assign left_v[i] = fill;
        end else begin : g_mid_l
            assign left_v[i] = acc[i-1];
        end
    end

    always_comb begin
        result   = go_left ? left_v : right_v;
        flag_out = go_left ? acc[WIDTH-1] : acc[0];
    end
endmodule

// File: rtl/dacc_alu.sv
module dacc_alu
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [3:0]       op_sel,
    input  logic [WIDTH-1:0] operand,
    output logic [WIDTH-1:0] d_out,
    output logic             df_out
);
    localparam int EXT_W = WIDTH + 1;

    logic [WIDTH-1:0] d_q;
    logic             df_q;

    op_class_e        cls;
    arith_ctl_t       actl;
    logic [WIDTH-1:0] logic_res;
    logic [WIDTH-1:0] arith_res;
    logic             arith_c;
    logic [WIDTH-1:0] shift_res;
    logic             shift_f;
    logic [WIDTH-1:0] d_nxt;
    logic             df_nxt;
    logic             df_wr;

    always_comb begin
        cls  = classify(op_sel);
        actl = arith_decode(op_sel);
    end

    acc_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .code   (op_sel),
        .acc    (d_q),
        .opnd   (operand),
        .result (logic_res)
    );

    acc_alu_arith #(.WIDTH(WIDTH)) u_arith (
        .ctl    (actl),
        .acc    (d_q),
        .opnd   (operand),
        .flag   (df_q),
        .result (arith_res),
        .carry  (arith_c)
    );

    acc_alu_shift #(.WIDTH(WIDTH)) u_shift (
        .code     (op_sel),
        .acc      (d_q),
        .flag     (df_q),
        .result   (shift_res),
        .flag_out (shift_f)
    );

    always_comb begin
        d_nxt  = d_q;
        df_nxt = df_q;
        df_wr  = 1'b0;
        case (cls)
            CLS_LOGIC: d_nxt = logic_res;
            CLS_ARITH: begin
                d_nxt  = arith_res;
                df_nxt = arith_c;
                df_wr  = 1'b1;
            end
            CLS_SHIFT: begin
                d_nxt  = shift_res;
                df_nxt = shift_f;
                df_wr  = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            d_q <= '0;
        end else if (we) begin
            d_q <= d_nxt;
        end
    end

    // The flag has no reset: it is only ever written by an operation.
    always_ff @(posedge clk) begin
        if (!rst && we && df_wr) begin
            df_q <= df_nxt;
        end
    end

    assign d_out  = d_q;
    assign df_out = df_q;

    // ---------------- assertions ----------------
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (d_q == '0));

    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!we && !$isunknown(df_q)) |=> ($stable(d_q) && $stable(df_q)));

    assert_logic_keeps_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (we && op_sel <= 4'd2 && !$isunknown(df_q)) |=> $stable(df_q));

    assert_add_sum_R4: assert property (@(posedge clk) disable iff (rst)
        (we && op_sel == 4'd3) |=>
        ({df_q, d_q} == ({1'b0, $past(operand)} + {1'b0, $past(d_q)})));

    assert_adc_sum_R5: assert property (@(posedge clk) disable iff (rst)
        (we && op_sel == 4'd4 && !$isunknown(df_q)) |=>
        ({df_q, d_q} == ({1'b0, $past(operand)} + {1'b0, $past(d_q)}
                         + {{WIDTH{1'b0}}, $past(df_q)})));

    assert_sub_noborrow_R6: assert property (@(posedge clk) disable iff (rst)
        (we && op_sel == 4'd6) |=>
        (df_q == ($past(d_q) >= $past(operand))));

    assert_sbb_noborrow_R7: assert property (@(posedge clk) disable iff (rst)
        (we && op_sel == 4'd7 && !$isunknown(df_q)) |=>
        (df_q == ({1'b0, $past(operand)} >=
                  ({1'b0, $past(d_q)} + {{WIDTH{1'b0}}, ~$past(df_q)}))));

    assert_shr_fill_R8: assert property (@(posedge clk) disable iff (rst)
        (we && op_sel == 4'd9) |=>
        (d_q[WIDTH-1] == 1'b0 && df_q == $past(d_q[0])));

    assert_rorc_fill_R9: assert property (@(posedge clk) disable iff (rst)
        (we && op_sel == 4'd10 && !$isunknown(df_q)) |=>
        (d_q[WIDTH-1] == $past(df_q) && df_q == $past(d_q[0])));

    assert_rolc_fill_R10: assert property (@(posedge clk) disable iff (rst)
        (we && op_sel == 4'd12 && !$isunknown(df_q)) |=>
        (d_q[0] == $past(df_q) && df_q == $past(d_q[WIDTH-1])));

    assert_reserved_noop_R11: assert property (@(posedge clk) disable iff (rst)
        (we && op_sel >= 4'd13 && !$isunknown(df_q)) |=>
        ($stable(d_q) && $stable(df_q)));

    // Width guard for the comparison helpers above.
    initial begin
        assert_width_sane_R4: assert (EXT_W == WIDTH + 1 && WIDTH >= 2);
    end

endmodule

// File: tb/dacc_alu_tb.sv
module dacc_alu_tb;

    localparam int W = 8;

    typedef struct packed {
        logic [3:0]   op;
        logic [W-1:0] opnd;
        logic [W-1:0] d_in;
        logic         df_in;
        logic [W-1:0] d_exp;
        logic         df_exp;
        logic [7:0]   req;
    } vec_t;

    localparam int NVEC = 25;
    localparam vec_t VECS [NVEC] = '{
        '{4'd0,  8'hF0, 8'h3C, 1'b1, 8'h30, 1'b1, 8'd3},
        '{4'd1,  8'h0F, 8'h30, 1'b0, 8'h3F, 1'b0, 8'd3},
        '{4'd2,  8'hFF, 8'h5A, 1'b1, 8'hA5, 1'b1, 8'd3},
        '{4'd3,  8'h80, 8'h80, 1'b1, 8'h00, 1'b1, 8'd4},
        '{4'd3,  8'h12, 8'h34, 1'b1, 8'h46, 1'b0, 8'd4},
        '{4'd4,  8'hFF, 8'h00, 1'b1, 8'h00, 1'b1, 8'd5},
        '{4'd4,  8'h10, 8'h20, 1'b1, 8'h31, 1'b0, 8'd5},
        '{4'd5,  8'h50, 8'h20, 1'b0, 8'h30, 1'b1, 8'd6},
        '{4'd5,  8'h20, 8'h50, 1'b1, 8'hD0, 1'b0, 8'd6},
        '{4'd6,  8'h20, 8'h50, 1'b0, 8'h30, 1'b1, 8'd6},
        '{4'd6,  8'h50, 8'h20, 1'b1, 8'hD0, 1'b0, 8'd6},
        '{4'd5,  8'h44, 8'h44, 1'b0, 8'h00, 1'b1, 8'd6},
        '{4'd7,  8'h50, 8'h20, 1'b0, 8'h2F, 1'b1, 8'd7},
        '{4'd7,  8'h20, 8'h20, 1'b0, 8'hFF, 1'b0, 8'd7},
        '{4'd7,  8'h20, 8'h20, 1'b1, 8'h00, 1'b1, 8'd7},
        '{4'd8,  8'h01, 8'h01, 1'b0, 8'hFF, 1'b0, 8'd7},
        '{4'd8,  8'h10, 8'h35, 1'b1, 8'h25, 1'b1, 8'd7},
        '{4'd9,  8'h00, 8'h81, 1'b0, 8'h40, 1'b1, 8'd8},
        '{4'd10, 8'h00, 8'h81, 1'b1, 8'hC0, 1'b1, 8'd9},
        '{4'd10, 8'hFF, 8'h02, 1'b1, 8'h81, 1'b0, 8'd9},
        '{4'd11, 8'h00, 8'h81, 1'b0, 8'h02, 1'b1, 8'd10},
        '{4'd12, 8'h00, 8'h81, 1'b1, 8'h03, 1'b1, 8'd10},
        '{4'd12, 8'h00, 8'h40, 1'b1, 8'h81, 1'b0, 8'd10},
        '{4'd13, 8'hAA, 8'h77, 1'b1, 8'h77, 1'b1, 8'd11},
        '{4'd15, 8'hFF, 8'h12, 1'b0, 8'h12, 1'b0, 8'd11}
    };

    logic         clk;
    logic         rst;
    logic         we;
    logic [3:0]   op_sel;
    logic [W-1:0] operand;
    logic [W-1:0] d_out;
    logic         df_out;

    int checks;
    int errors;
    bit done;

    dacc_alu #(.WIDTH(W)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .we      (we),
        .op_sel  (op_sel),
        .operand (operand),
        .d_out   (d_out),
        .df_out  (df_out)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Drive at the falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic step(input logic r, input logic w, input logic [3:0] op, input logic [W-1:0] v);
        rst     = r;
        we      = w;
        op_sel  = op;
        operand = v;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        we  = 1'b0;
    endtask

    task automatic check(input string req, input logic [W-1:0] exp_d, input logic exp_df);
        checks++;
        if (d_out !== exp_d || df_out !== exp_df) begin
            errors++;
            $display("FAIL %s: got d=%02h df=%0b, expected d=%02h df=%0b",
                     req, d_out, df_out, exp_d, exp_df);
        end
    endtask

    // Put a known byte and flag into the unit using reset, shifts and OR only.
    task automatic preload(input logic [W-1:0] dv, input logic fv);
        step(1'b1, 1'b0, 4'd0, '0);
        if (fv) begin
            step(1'b0, 1'b1, 4'd1, 8'h80);
            step(1'b0, 1'b1, 4'd11, 8'h00);
        end else begin
            step(1'b0, 1'b1, 4'd9, 8'h00);
        end
        step(1'b0, 1'b1, 4'd1, dv);
    endtask

    initial begin
        checks = 0;
        errors = 0;
        done   = 1'b0;
        rst     = 1'b1;
        we      = 1'b0;
        op_sel  = 4'd0;
        operand = '0;
        @(negedge clk);
        step(1'b1, 1'b0, 4'd0, '0);
        checks++;
        if (d_out !== 8'h00) begin
            errors++;
            $display("FAIL R1: got d=%02h, expected d=00 after reset", d_out);
        end

        for (int i = 0; i < NVEC; i++) begin
            preload(VECS[i].d_in, VECS[i].df_in);
            step(1'b0, 1'b1, VECS[i].op, VECS[i].opnd);
            check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].d_exp, VECS[i].df_exp);
        end

        // R1: reset with the strobe high clears the accumulator, flag survives
        preload(8'h5A, 1'b1);
        step(1'b1, 1'b1, 4'd3, 8'hFF);
        check("R1 reset keeps flag=1", 8'h00, 1'b1);
        preload(8'hA5, 1'b0);
        step(1'b1, 1'b1, 4'd11, 8'h00);
        check("R1 reset keeps flag=0", 8'h00, 1'b0);

        // R2: strobe low leaves everything unchanged
        preload(8'hC3, 1'b1);
        step(1'b0, 1'b0, 4'd3, 8'h7F);
        check("R2 add without strobe", 8'hC3, 1'b1);
        step(1'b0, 1'b0, 4'd9, 8'h00);
        check("R2 shift without strobe", 8'hC3, 1'b1);
        step(1'b0, 1'b0, 4'd0, 8'h00);
        check("R2 and without strobe", 8'hC3, 1'b1);

        // R5 with R3: two-byte add 0x01FF + 0x0001, flag carried across an OR
        preload(8'hFF, 1'b0);
        step(1'b0, 1'b1, 4'd3, 8'h01);
        check("R4 low byte add", 8'h00, 1'b1);
        step(1'b0, 1'b1, 4'd1, 8'h01);
        check("R3 OR keeps carry", 8'h01, 1'b1);
        step(1'b0, 1'b1, 4'd4, 8'h00);
        check("R5 high byte adc", 8'h02, 1'b0);

        // R11: reserved code 14
        preload(8'h3E, 1'b0);
        step(1'b0, 1'b1, 4'd14, 8'hFF);
        check("R11 code 14", 8'h3E, 1'b0);

        // R8: shifting zero right keeps zero and clears the flag
        preload(8'h00, 1'b1);
        step(1'b0, 1'b1, 4'd9, 8'h00);
        check("R8 zero right", 8'h00, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule